// File: doc/BRIEF.md
# Dual-Port Two-Word-Burst DDR SRAM

This block is a synthesizable model of a synchronous static memory with a dedicated write-data port and a separate read-data port. Both ports share one address bus, which carries the read address in one half of each clock cycle and the write address in the other half. Every access moves two consecutive words. The memory therefore behaves as an even word bank and an odd word bank that share one burst address.

The double-data-rate timing is modelled with a single clock at twice the command rate. An internal phase bit marks each rising edge as either the primary edge (K) or the complementary edge (K#). The edge on which reset is released is followed by a K edge, and the edges then alternate. A read started on a K edge returns its even word three edges later, which is 1.5 command cycles, and its odd word on the edge after that. A write started on a K edge takes its address and its first data word on the next K# edge, and its second data word on the K edge after that. Reads and writes run independently and may overlap. A read that overlaps a write to the same burst address returns the newly written lanes.

A free-running echo strobe marks the phase of the output beats. The output-drive flag stands in for a tri-state enable and also serves as the data-valid flag.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst` is high, `q_drive`, `rdata` and `echo_q` are all 0, and port selects are ignored. The first rising edge after `rst` falls is a K edge.
- R2: With `rd_sel_n` low on a K edge, the address on that edge is latched as the read burst address. The even word appears on `rdata` after the K# edge three edges later. The odd word follows after the next K edge. `q_drive` is high for exactly those two half-cycles.
- R3: With `wr_sel_n` low on a K edge, a write burst starts. The following K# edge latches the write address from `addr` and writes the even word from `wdata`. The next K edge writes the odd word from `wdata` to the same address.
- R4: `wmask_n` is active-low and is sampled on the same edge as the word it qualifies. Bit 0 guards `wdata[8:0]` and bit 1 guards `wdata[17:9]`. A lane whose mask bit is 1 keeps its stored value.
- R5: While the write port is deselected, `addr`, `wdata` and `wmask_n` change no stored word.
- R6: If `rd_sel_n` is high on a K edge, no new burst starts. A burst that was already accepted still completes, after which `q_drive` falls on the next edge.
- R7: A read and a write may both start on the same K edge and proceed independently. A read that starts in the same cycle as a write to its address returns the written data.
- R8: When a write beat is stored on the same edge on which a read beat of the same bank and address is output, the output carries the new data in the written lanes and the old data in the masked lanes.
- R9: `echo_q` toggles on every edge. It is 1 after a K edge and 0 after a K# edge, so the even read word is always driven while `echo_q` is 0.
- R10: Reads issued on consecutive K edges keep `q_drive` continuously high, with the words in issue order.
- R11: `rdata` is all zeros whenever `q_drive` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each rising edge is a K or K# edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low read start, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write start, sampled on K edges |
| addr | input | AW | Shared address: read address on K, write address on K# |
| wdata | input | DW | Write data word, one per edge during a write burst |
| wmask_n | input | LANES | Active-low per-lane write enables for the current word |
| rdata | output | DW | Read data word, zero when not driving |
| q_drive | output | 1 | Output enable and data-valid flag |
| echo_q | output | 1 | Free-running strobe, 1 after K edges and 0 after K# edges |

## Verification
A stale or misaligned phase bit shows up at the ports at once: `echo_q` stops toggling or takes the wrong polarity on the first edge after reset. Every read beat would also land on the wrong bank. A fault in the command pipeline shows up within four edges as a missing, shifted or extra `q_drive` half-cycle. A fault in the bank write path or the lane merge only shows up when that address is read again, so the bench first fills every address with distinct patterns and then reads back after each write. Forwarding errors are only visible when a write beat is stored on the same edge as a read beat, so the bench creates that overlap deliberately and also lets random traffic produce it.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    // Default geometry: 64 burst addresses, 18-bit words, two 9-bit lanes.
    localparam int QDR_AW_DEF    = 6;
    localparam int QDR_DW_DEF    = 18;
    localparam int QDR_LANES_DEF = 2;
    localparam int QDR_NBANKS    = 2;

    // Which rising edge of the double-rate clock is about to occur.
    typedef enum logic {
        EDGE_K  = 1'b0,
        EDGE_KN = 1'b1
    } edge_e;

    // Which word of a two-word burst.
    typedef enum logic {
        BEAT_EVEN = 1'b0,
        BEAT_ODD  = 1'b1
    } beat_e;

    function automatic edge_e next_edge(input edge_e cur);
        return (cur == EDGE_K) ? EDGE_KN : EDGE_K;
    endfunction

    // The bank served on a given edge: even words on K#, odd words on K.
    function automatic beat_e bank_of_edge(input edge_e cur);
        return (cur == EDGE_KN) ? BEAT_EVEN : BEAT_ODD;
    endfunction

endpackage

// File: rtl/qdr_phase_ctl.sv
module qdr_phase_ctl
    import qdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output edge_e cur_edge,
    output logic  echo_q
);

    edge_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= EDGE_K;
        end else begin
            phase_q <= next_edge(phase_q);
        end
    end

    assign cur_edge = phase_q;
    // After a K edge the phase reads K#, so the strobe is high in that half.
    assign echo_q   = (phase_q == EDGE_KN);

endmodule

// File: rtl/qdr_cmd_ctl.sv
module qdr_cmd_ctl
    import qdr_pkg::*;
#(
    parameter int AW = QDR_AW_DEF
)(
    input  logic                   clk,
    input  logic                   rst,
    input  edge_e                  cur_edge,
    input  logic                   rd_sel_n,
    input  logic                   wr_sel_n,
    input  logic [AW-1:0]          addr,
    output logic [QDR_NBANKS-1:0]  wr_en,
    output logic [AW-1:0]          wr_addr,
    output logic                   rd_fire,
    output beat_e                  rd_bank,
    output logic [AW-1:0]          rd_addr
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] adr;
    } rd_slot_t;

    rd_slot_t rd_new_q;     // accepted on the latest K edge
    rd_slot_t rd_out_q;     // burst currently on the output
    logic          wr_go_q;     // write started on the latest K edge
    logic          wr_odd_q;    // odd beat due on the coming K edge
    logic [AW-1:0] wr_addr_q;

    wire on_k  = (cur_edge == EDGE_K);
    wire on_kn = (cur_edge == EDGE_KN);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_new_q  <= '0;
            rd_out_q  <= '0;
            wr_go_q   <= 1'b0;
            wr_odd_q  <= 1'b0;
            wr_addr_q <= '0;
        end else if (on_k) begin
            rd_out_q     <= rd_new_q;
            rd_new_q.vld <= !rd_sel_n;
            if (!rd_sel_n) begin
                rd_new_q.adr <= addr;
            end
            wr_go_q  <= !wr_sel_n;
            wr_odd_q <= 1'b0;
        end else begin
            wr_odd_q <= wr_go_q;
            if (wr_go_q) begin
                wr_addr_q <= addr;
            end
        end
    end

    // Write commit: even word on K# (address straight from the bus),
    // odd word on the following K edge (address held).
    always_comb begin
        wr_en                   = '0;
        wr_en[int'(BEAT_EVEN)]  = on_kn && wr_go_q;
        wr_en[int'(BEAT_ODD)]   = on_k  && wr_odd_q;
        wr_addr                 = on_kn ? addr : wr_addr_q;
    end

    assign rd_fire = rd_out_q.vld;
    assign rd_bank = bank_of_edge(cur_edge);
    assign rd_addr = rd_out_q.adr;

endmodule

// File: rtl/qdr_bank.sv
module qdr_bank
    import qdr_pkg::*;
#(
    parameter int AW    = QDR_AW_DEF,
    parameter int DW    = QDR_DW_DEF,
    parameter int LANES = QDR_LANES_DEF
)(
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] wmask_n,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int LW    = DW / LANES;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wmask_n[l]) begin
                    mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/qdr_read_out.sv
module qdr_read_out
    import qdr_pkg::*;
#(
    parameter int AW    = QDR_AW_DEF,
    parameter int DW    = QDR_DW_DEF,
    parameter int LANES = QDR_LANES_DEF
)(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_fire,
    input  beat_e                          rd_bank,
    input  logic [AW-1:0]                  rd_addr,
    input  logic [QDR_NBANKS-1:0][DW-1:0]  bank_q,
    input  logic [QDR_NBANKS-1:0]          wr_en,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [DW-1:0]                  wdata,
    input  logic [LANES-1:0]               wmask_n,
    output logic [DW-1:0]                  rdata,
    output logic                           q_drive
);

    localparam int LW = DW / LANES;

    logic [DW-1:0] merged;
    logic          fwd_hit;

    always_comb begin
        fwd_hit = wr_en[int'(rd_bank)] && (wr_addr == rd_addr);
        merged  = bank_q[int'(rd_bank)];
        for (int l = 0; l < LANES; l++) begin
            if (fwd_hit && !wmask_n[l]) begin
                merged[l*LW +: LW] = wdata[l*LW +: LW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            q_drive <= 1'b0;
        end else begin
            q_drive <= rd_fire;
            rdata   <= rd_fire ? merged : '0;
        end
    end

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
    import qdr_pkg::*;
#(
    parameter int AW    = QDR_AW_DEF,
    parameter int DW    = QDR_DW_DEF,
    parameter int LANES = QDR_LANES_DEF
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_sel_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] wmask_n,
    output logic [DW-1:0]    rdata,
    output logic             q_drive,
    output logic             echo_q
);

    edge_e                          cur_edge;
    logic [QDR_NBANKS-1:0]          wr_en;
    logic [AW-1:0]                  wr_addr;
    logic                           rd_fire;
    beat_e                          rd_bank;
    logic [AW-1:0]                  rd_addr;
    logic [QDR_NBANKS-1:0][DW-1:0]  bank_q;

    qdr_phase_ctl u_phase (
        .clk      (clk),
        .rst      (rst),
        .cur_edge (cur_edge),
        .echo_q   (echo_q)
    );

    qdr_cmd_ctl #(.AW(AW)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cur_edge (cur_edge),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_fire  (rd_fire),
        .rd_bank  (rd_bank),
        .rd_addr  (rd_addr)
    );

    for (genvar b = 0; b < QDR_NBANKS; b++) begin : g_bank
        qdr_bank #(.AW(AW), .DW(DW), .LANES(LANES)) u_bank (
            .clk     (clk),
            .we      (wr_en[b]),
            .waddr   (wr_addr),
            .wdata   (wdata),
            .wmask_n (wmask_n),
            .raddr   (rd_addr),
            .rdata   (bank_q[b])
        );
    end

    qdr_read_out #(.AW(AW), .DW(DW), .LANES(LANES)) u_out (
        .clk     (clk),
        .rst     (rst),
        .rd_fire (rd_fire),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .bank_q  (bank_q),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wdata   (wdata),
        .wmask_n (wmask_n),
        .rdata   (rdata),
        .q_drive (q_drive)
    );

endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
    parameter int DW = 18
)(
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] rdata,
    input logic          q_drive,
    input logic          echo_q
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!q_drive && !echo_q)); // R1

    AST_ECHO_TOGGLE: assert property (@(posedge clk) disable iff (rst || !armed)
        !$stable(echo_q)); // R9

    AST_BURST_PAIR: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(q_drive) |=> q_drive); // R2

    AST_EVEN_BEAT_PHASE: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(q_drive) |-> !echo_q); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !q_drive |-> (rdata == '0)); // R11

endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rdata   (rdata),
    .q_drive (q_drive),
    .echo_q  (echo_q)
);

// File: tb/sim_qdr_burst_sram.sv
module sim_qdr_burst_sram;

    localparam int AW    = 6;
    localparam int DW    = 18;
    localparam int LANES = 2;
    localparam int LW    = DW / LANES;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_sel_n = 1'b1;
    logic             wr_sel_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [LANES-1:0] wmask_n = '1;
    logic [DW-1:0]    rdata;
    logic             q_drive;
    logic             echo_q;

    always #2 clk = ~clk;

    qdr_burst_sram #(.AW(AW), .DW(DW), .LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata(wdata), .wmask_n(wmask_n),
        .rdata(rdata), .q_drive(q_drive), .echo_q(echo_q)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference memory and edge-slot schedule.
    logic [DW-1:0] me [DEPTH];
    logic [DW-1:0] mo [DEPTH];
    logic          rs_v [8];
    logic          rs_b [8];
    logic [AW-1:0] rs_a [8];
    logic          ws_e [8];
    logic          ws_o [8];
    logic [AW-1:0] ws_a [8];
    int            n_edge = 0;
    logic [DW-1:0]    pend_d = '0;
    logic [LANES-1:0] pend_m = '1;

    function automatic logic [DW-1:0] f_merge(input logic [DW-1:0] old_w,
                                              input logic [DW-1:0] new_w,
                                              input logic [LANES-1:0] m_n);
        logic [DW-1:0] r = old_w;
        for (int l = 0; l < LANES; l++)
            if (!m_n[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h (edge %0d)",
                     req, what, act, exp, n_edge);
        end
    endtask

    // One rising edge: update the reference, clock, then compare outputs.
    task automatic edge_step();
        int s = n_edge % 8;
        logic exp_drv;
        logic [DW-1:0] exp_dat;
        if (n_edge % 2 == 0) begin
            if (ws_o[s]) mo[ws_a[s]] = f_merge(mo[ws_a[s]], wdata, wmask_n);
            ws_o[s] = 1'b0;
            if (!wr_sel_n) ws_e[(n_edge + 1) % 8] = 1'b1;
            if (!rd_sel_n) begin
                rs_v[(n_edge + 3) % 8] = 1'b1; rs_b[(n_edge + 3) % 8] = 1'b0;
                rs_a[(n_edge + 3) % 8] = addr;
                rs_v[(n_edge + 4) % 8] = 1'b1; rs_b[(n_edge + 4) % 8] = 1'b1;
                rs_a[(n_edge + 4) % 8] = addr;
            end
        end else begin
            if (ws_e[s]) begin
                me[addr] = f_merge(me[addr], wdata, wmask_n);
                ws_o[(n_edge + 1) % 8] = 1'b1;
                ws_a[(n_edge + 1) % 8] = addr;
            end
            ws_e[s] = 1'b0;
        end
        exp_drv = rs_v[s];
        exp_dat = !rs_v[s] ? '0 : (rs_b[s] ? mo[rs_a[s]] : me[rs_a[s]]);
        rs_v[s] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, "q_drive", 32'(q_drive), 32'(exp_drv));
        chk(cur_req, "rdata", 32'(rdata), 32'(exp_dat));
        chk("R9", "echo_q", 32'(echo_q), 32'(n_edge % 2 == 0));
        n_edge++;
    endtask

    // One command cycle (K edge then K# edge). Odd write word of the
    // previous cycle rides on this cycle's K edge.
    task automatic do_cycle(input bit rd, input logic [AW-1:0] ra,
                            input bit wr, input logic [AW-1:0] wa,
                            input logic [DW-1:0] d0, input logic [LANES-1:0] m0,
                            input logic [DW-1:0] d1, input logic [LANES-1:0] m1);
        rd_sel_n = !rd;
        wr_sel_n = !wr;
        addr     = ra;
        wdata    = pend_d;
        wmask_n  = pend_m;
        edge_step();
        rd_sel_n = $urandom_range(0, 1);
        wr_sel_n = $urandom_range(0, 1);
        addr     = wa;
        wdata    = d0;
        wmask_n  = m0;
        edge_step();
        pend_d = wr ? d1 : DW'($urandom);
        pend_m = wr ? m1 : LANES'($urandom);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            do_cycle(0, AW'($urandom), 0, AW'($urandom), DW'($urandom),
                     LANES'($urandom), DW'($urandom), LANES'($urandom));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            rs_v[i] = 0; rs_b[i] = 0; rs_a[i] = '0;
            ws_e[i] = 0; ws_o[i] = 0; ws_a[i] = '0;
        end
        void'($urandom(32'h51A7));
        // R1: reset holds outputs quiet even with both ports selected.
        rd_sel_n = 1'b0;
        wr_sel_n = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R1", "q_drive in reset", 32'(q_drive), 32'd0);
        chk("R1", "rdata in reset", 32'(rdata), 32'd0);
        chk("R1", "echo_q in reset", 32'(echo_q), 32'd0);
        rd_sel_n = 1'b1;
        wr_sel_n = 1'b1;
        rst = 1'b0;

        // R3: fill every address, writes back to back.
        cur_req = "R3";
        for (int a = 0; a < DEPTH; a++)
            do_cycle(0, '0, 1, AW'(a), DW'(a * 37 + 5), '0, DW'(a * 91 + 3), '0);
        idle(1);

        // R2: single read.
        cur_req = "R2";
        do_cycle(1, 6'd5, 0, '0, '0, '1, '0, '1);
        idle(3);

        // R10: reads on consecutive K edges.
        cur_req = "R10";
        do_cycle(1, 6'd1, 0, '0, '0, '1, '0, '1);
        do_cycle(1, 6'd2, 0, '0, '0, '1, '0, '1);
        do_cycle(1, 6'd63, 0, '0, '0, '1, '0, '1);
        idle(3);

        // R4: lane masks (lane 0 only on even word, lane 1 only on odd word).
        cur_req = "R4";
        do_cycle(0, '0, 1, 6'd7, 18'h2AAAA, 2'b10, 18'h15555, 2'b01);
        idle(1);
        do_cycle(1, 6'd7, 0, '0, '0, '1, '0, '1);
        idle(3);

        // R5: write port deselected with live address and data.
        cur_req = "R5";
        do_cycle(0, '0, 0, 6'd7, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00);
        idle(1);
        do_cycle(1, 6'd7, 0, '0, '0, '1, '0, '1);
        idle(3);

        // R6: deselect after one read; burst completes, then drive drops.
        cur_req = "R6";
        do_cycle(1, 6'd9, 0, '0, '0, '1, '0, '1);
        idle(4);

        // R7: read and write to the same address started in one cycle.
        cur_req = "R7";
        do_cycle(1, 6'd11, 1, 6'd11, 18'h0BEEF, 2'b00, 18'h1CAFE, 2'b00);
        idle(3);

        // R8: write one cycle after the read, beats stored as they are output.
        cur_req = "R8";
        do_cycle(1, 6'd12, 0, '0, '0, '1, '0, '1);
        do_cycle(0, '0, 1, 6'd12, 18'h01234, 2'b00, 18'h3ABCD, 2'b10);
        idle(3);

        // R7: random mixed traffic.
        cur_req = "R7";
        for (int i = 0; i < 1500; i++)
            do_cycle($urandom_range(0, 2) != 0, AW'($urandom),
                     $urandom_range(0, 2) != 0, AW'($urandom),
                     DW'($urandom), LANES'($urandom),
                     DW'($urandom), LANES'($urandom));
        idle(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule